// File: doc/BRIEF.md
# Dual-Channel Memory Fill Engine

The engine writes a constant pattern across a byte range of memory. Software programs one of two independent channels with a start address, an end address, a pattern value and a pair of width flags, then sets the channel's trigger bit. The channel walks the range one 32-bit word at a time. It raises byte enables only for the bytes that belong to whole pattern elements inside the range, and it issues each word on a shared valid/ready write port.

Three element widths are supported: 16-bit, 32-bit and a packed three-byte colour triple. The triple is laid across word boundaries through the byte enables. When both channels have work, channel 0 takes the port first, but a word that is already on the port is never taken away from its owner. When a channel finishes, it drops its trigger bit, sets its finished bit and pulses its own interrupt line. A start address of zero is treated as an invalid request: the trigger/finished exchange still happens, but nothing is written and no interrupt is raised.

Top module: `fill_engine`

## Requirements
- R1: Registers are selected by `reg_waddr`/`reg_raddr`: bits [top:2] pick the channel, bits [1:0] pick the register (0 start address, 1 end address, 2 pattern value, 3 control). Control bits are [0] trigger/busy, [1] finished, [2] 32-bit flag and [3] 24-bit flag. Reads return the stored values, zero-extended.
- R2: The element width follows a priority. If control bit 3 is set, the width is 3 bytes. Otherwise, if bit 2 is set, it is 4 bytes. Otherwise it is 2 bytes.
- R3: Byte lane k of `mem_wdata` (bits 8k+7:8k) and `mem_be[k]` belong to byte address `mem_addr`+k, and `mem_addr` is word aligned. A 2-byte element is written as value[7:0] then value[15:8] at ascending addresses. A 4-byte element is written as value[7:0] up to value[31:24]. A 3-byte element is written as value[23:16], value[15:8], value[7:0]. Elements follow one another with no gap, starting at the start address.
- R4: Only bytes of elements that lie wholly in [start, end) are written. A partial final element is dropped. A word with no enabled byte is never issued. Words are issued in ascending address order.
- R5: A trigger with start address 0 writes no memory and raises no interrupt. From the next cycle the trigger bit reads 0 and the finished bit reads 1.
- R6: When a triggered fill ends, the trigger bit reads 0 and the finished bit reads 1. The channel's `irq` bit is high for exactly one cycle: the cycle after the last word is accepted, or the cycle after the trigger write if no whole element fits.
- R7: While a channel is busy, every register write to that channel is ignored, including a new trigger.
- R8: The finished bit clears only when a control write has bit 1 = 0. A control write with bit 1 = 1 leaves it unchanged.
- R9: Channel 0 wins the port when both channels are waiting. While `mem_valid` is high and `mem_ready` is low, the owner, `mem_addr`, `mem_wdata` and `mem_be` hold.
- R10: After reset, all registers read 0, `mem_valid` is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | idx_w(NCH)+2 | Register write address (channel, register) |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | idx_w(NCH)+2 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_valid | output | 1 | Write word is on the port |
| mem_ready | input | 1 | Memory accepts the word this cycle |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, lane k at address+k |
| mem_be | output | 4 | Byte enables |
| irq | output | NCH | Per-channel completion pulse |

## Verification
The bench builds the engine with ADDR_W=16 and NCH=2. The narrow address puts channel 1's regions in the upper half of the space, so each accepted word can be matched to its channel's scoreboard by address bit 15 alone. With two channels, the bench can start a long fill on channel 1 and then trigger channel 0 in the middle of it. This exercises fixed priority and the rule that the port is held during a stall. Unaligned starts and ends in all three widths reach partial first words, partial final elements and triples that straddle a word boundary.

// File: rtl/fill_pkg.sv
// Shared constants and helpers for the fill engine.
// Assumes byte-addressed memory with little-endian lanes in a 32-bit word.
package fill_pkg;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_END   = 2'd1;
    localparam logic [1:0] SEL_VALUE = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    // Bits needed to index n channels (at least one).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Element size in bytes; the triple flag beats the word flag (R2).
    function automatic logic [2:0] elem_bytes(input logic f24, input logic f32);
        if (f24)      return 3'd3;
        else if (f32) return 3'd4;
        else          return 3'd2;
    endfunction

    // Pattern byte for a given position inside an element (R3).
    function automatic logic [7:0] pat_byte(input logic [31:0] v, input logic [2:0] esz,
                                            input logic [2:0] ph);
        if (esz == 3'd3) begin
            case (ph)
                3'd0:    return v[23:16];
                3'd1:    return v[15:8];
                default: return v[7:0];
            endcase
        end
        case (ph)
            3'd0:    return v[7:0];
            3'd1:    return v[15:8];
            3'd2:    return v[23:16];
            default: return v[31:24];
        endcase
    endfunction

endpackage

// File: rtl/fill_word_gen.sv
// Builds one memory word from a fill cursor. Given the next byte to write
// (cur), its position inside the current element (phase), the region end and
// the element size, it produces data and byte enables and the cursor for the
// following word. It also reports whether that following word would be empty.
// Assumes 0 <= phase < esz and esz in {2,3,4}.
module fill_word_gen #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [2:0]        phase,
    input  logic [ADDR_W-1:0] lim,
    input  logic [2:0]        esz,
    input  logic [31:0]       value,
    output logic [ADDR_W-1:0] waddr,
    output logic [31:0]       wdata,
    output logic [3:0]        be,
    output logic [ADDR_W-1:0] nxt_cur,
    output logic [2:0]        nxt_phase,
    output logic              last
);
    import fill_pkg::*;

    localparam int AW1 = ADDR_W + 1;

    logic [AW1-1:0] nxt_wide;

    assign waddr = {cur[ADDR_W-1:2], 2'b00};

    // One lane per byte: a lane is written when its whole element ends at or below lim.
    for (genvar k = 0; k < 4; k++) begin : g_lane
        logic           in_word;
        logic [2:0]     ph_sum;
        logic [2:0]     lane_ph;
        logic [AW1-1:0] baddr;
        logic [AW1-1:0] elem_end;
        assign in_word  = (2'(k) >= cur[1:0]);
        assign ph_sum   = phase + 3'(k) - {1'b0, cur[1:0]};
        assign lane_ph  = ph_sum % esz;
        assign baddr    = {1'b0, cur[ADDR_W-1:2], 2'(k)};
        assign elem_end = baddr + AW1'(esz) - AW1'(lane_ph);
        assign be[k]    = in_word && (elem_end <= {1'b0, lim});
        assign wdata[8*k +: 8] = be[k] ? pat_byte(value, esz, lane_ph) : 8'h00;
    end

    // Cursor for the next word, and whether any of its bytes could be written.
    assign nxt_wide  = {1'b0, cur[ADDR_W-1:2], 2'b00} + AW1'(4);
    assign nxt_cur   = nxt_wide[ADDR_W-1:0];
    assign nxt_phase = (phase + (3'd4 - {1'b0, cur[1:0]})) % esz;
    assign last      = (nxt_wide + AW1'(esz) - AW1'(nxt_phase)) > {1'b0, lim};

endmodule

// File: rtl/fill_chan.sv
// One fill channel: its configuration registers, the trigger/finished
// handshake, the walking cursor and the completion pulse. A write to the
// channel while it is busy is dropped. Assumes ADDR_W <= 32.
module fill_chan #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    output logic [ADDR_W-1:0] rd_start,
    output logic [ADDR_W-1:0] rd_end,
    output logic [31:0]       rd_value,
    output logic [3:0]        rd_ctrl,
    output logic              req,
    input  logic              accept,
    output logic [ADDR_W-1:0] waddr,
    output logic [31:0]       wdata,
    output logic [3:0]        be,
    output logic              irq
);
    import fill_pkg::*;

    localparam int AW1 = ADDR_W + 1;

    logic [ADDR_W-1:0] start_q, end_q, cur_q, nxt_cur;
    logic [31:0]       value_q;
    logic              f24_q, f32_q, busy_q, fin_q, irq_q, last;
    logic [2:0]        ph_q, nxt_ph, esz, esz_new;
    logic              ctrl_wr, no_elem;

    assign esz     = elem_bytes(f24_q, f32_q);
    assign esz_new = elem_bytes(wr_data[3], wr_data[2]);
    assign ctrl_wr = wr_en && !busy_q && (wr_sel == SEL_CTRL);
    assign no_elem = ({1'b0, start_q} + AW1'(esz_new)) > {1'b0, end_q};

    fill_word_gen #(.ADDR_W(ADDR_W)) u_gen (
        .cur(cur_q), .phase(ph_q), .lim(end_q), .esz(esz), .value(value_q),
        .waddr(waddr), .wdata(wdata), .be(be),
        .nxt_cur(nxt_cur), .nxt_phase(nxt_ph), .last(last)
    );

    // Register writes, trigger handling and cursor advance on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            value_q <= '0;
            f24_q   <= 1'b0;
            f32_q   <= 1'b0;
            busy_q  <= 1'b0;
            fin_q   <= 1'b0;
            irq_q   <= 1'b0;
            cur_q   <= '0;
            ph_q    <= '0;
        end else begin
            irq_q <= 1'b0;
            if (wr_en && !busy_q) begin
                case (wr_sel)
                    SEL_START: start_q <= wr_data[ADDR_W-1:0];
                    SEL_END:   end_q   <= wr_data[ADDR_W-1:0];
                    SEL_VALUE: value_q <= wr_data;
                    default: begin
                        f24_q <= wr_data[3];
                        f32_q <= wr_data[2];
                        fin_q <= fin_q & wr_data[1];
                        if (wr_data[0]) begin
                            if (start_q == '0) begin
                                fin_q <= 1'b1;
                            end else if (no_elem) begin
                                fin_q <= 1'b1;
                                irq_q <= 1'b1;
                            end else begin
                                busy_q <= 1'b1;
                                cur_q  <= start_q;
                                ph_q   <= '0;
                            end
                        end
                    end
                endcase
            end
            if (busy_q && accept) begin
                cur_q <= nxt_cur;
                ph_q  <= nxt_ph;
                if (last) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                    irq_q  <= 1'b1;
                end
            end
        end
    end

    assign rd_start = start_q;
    assign rd_end   = end_q;
    assign rd_value = value_q;
    assign rd_ctrl  = {f24_q, f32_q, fin_q, busy_q};
    assign req      = busy_q;
    assign irq      = irq_q;

    assert_no_empty_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (be != 4'b0000));
    assert_cursor_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cur_q >= start_q && cur_q < end_q));
    assert_zero_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[0] && start_q == '0) |=> (!busy_q && fin_q && !irq_q));
    assert_done_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (fin_q && !busy_q));
    assert_busy_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ($stable(start_q) && $stable(end_q) && $stable(value_q)));

endmodule

// File: rtl/fill_arb.sv
// Fixed-priority port arbiter: the lowest-numbered requesting channel wins,
// but the owner is kept while its word is stalled on the port.
// Assumes a requester's request only drops on an accepted word.
module fill_arb #(
    parameter int NCH  = 2,
    parameter int CH_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  req,
    input  logic            hold,
    output logic [CH_W-1:0] grant
);
    logic [CH_W-1:0] pick, owner_q;
    logic            lock_q;

    // Lowest index with a request.
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) pick = CH_W'(i);
        end
    end

    assign grant = lock_q ? owner_q : pick;

    // Remember the owner of a stalled word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            owner_q <= '0;
        end else begin
            lock_q  <= hold;
            owner_q <= grant;
        end
    end

endmodule

// File: rtl/fill_engine.sv
// Top of the fill engine: NCH channels behind one register window, sharing
// one 32-bit write port through a fixed-priority arbiter.
// Assumes ADDR_W <= 32 and a memory that takes one word per handshake.
module fill_engine #(
    parameter int ADDR_W = 32,
    parameter int NCH    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr,
    input  logic [fill_pkg::idx_w(NCH)+1:0]    reg_waddr,
    input  logic [31:0]                        reg_wdata,
    input  logic [fill_pkg::idx_w(NCH)+1:0]    reg_raddr,
    output logic [31:0]                        reg_rdata,
    output logic                               mem_valid,
    input  logic                               mem_ready,
    output logic [ADDR_W-1:0]                  mem_addr,
    output logic [31:0]                        mem_wdata,
    output logic [3:0]                         mem_be,
    output logic [NCH-1:0]                     irq
);
    import fill_pkg::*;

    localparam int CH_W = idx_w(NCH);
    localparam int RA_W = CH_W + 2;

    logic [ADDR_W-1:0] ch_start [NCH];
    logic [ADDR_W-1:0] ch_end   [NCH];
    logic [31:0]       ch_value [NCH];
    logic [3:0]        ch_ctrl  [NCH];
    logic [ADDR_W-1:0] ch_addr  [NCH];
    logic [31:0]       ch_data  [NCH];
    logic [3:0]        ch_be    [NCH];
    logic [NCH-1:0]    ch_req;
    logic [CH_W-1:0]   grant;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        fill_chan #(.ADDR_W(ADDR_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_en(reg_wr && (reg_waddr[RA_W-1:2] == CH_W'(i))),
            .wr_sel(reg_waddr[1:0]), .wr_data(reg_wdata),
            .rd_start(ch_start[i]), .rd_end(ch_end[i]),
            .rd_value(ch_value[i]), .rd_ctrl(ch_ctrl[i]),
            .req(ch_req[i]),
            .accept(mem_valid && mem_ready && (grant == CH_W'(i))),
            .waddr(ch_addr[i]), .wdata(ch_data[i]), .be(ch_be[i]),
            .irq(irq[i])
        );
    end

    fill_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(ch_req),
        .hold(mem_valid && !mem_ready), .grant(grant)
    );

    assign mem_valid = ch_req[grant];
    assign mem_addr  = ch_addr[grant];
    assign mem_wdata = ch_data[grant];
    assign mem_be    = ch_be[grant];

    // Register read mux over channels and register selects.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (reg_raddr[RA_W-1:2] == CH_W'(i)) begin
                case (reg_raddr[1:0])
                    SEL_START: reg_rdata = 32'(ch_start[i]);
                    SEL_END:   reg_rdata = 32'(ch_end[i]);
                    SEL_VALUE: reg_rdata = ch_value[i];
                    default:   reg_rdata = 32'(ch_ctrl[i]);
                endcase
            end
        end
    end

    assert_stall_holds_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_wdata) && $stable(mem_be)));
    assert_stall_holds_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (grant == $past(grant)));
    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

endmodule

// File: tb/fill_engine_test.sv
`timescale 1ns/100ps
module fill_engine_test;

    localparam int AW = 16;

    typedef struct {
        logic [15:0] a;
        logic [31:0] d;
        logic [3:0]  be;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic [1:0]  irq;

    int    checks = 0;
    int    failures = 0;
    item_t q0[$];
    item_t q1[$];
    logic [1:0] exp_irq = 2'b00;
    bit    rdy_rand = 1'b0;
    bit    ch0_armed = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit    hold_prev = 1'b0;
    logic [15:0] prev_a;
    logic [31:0] prev_d;
    logic [3:0]  prev_be;

    always #2.5 clk = ~clk;

    fill_engine #(.ADDR_W(AW), .NCH(2)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Driver helpers: called just after a rising edge.
    task automatic reg_write(input int ch, input int sel, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_waddr = 3'(ch * 4 + sel);
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int ch, input int sel, output logic [31:0] d);
        reg_raddr = 3'(ch * 4 + sel);
        #0.5;
        d = reg_rdata;
    endtask

    task automatic push_item(input int ch, input item_t it);
        if (ch == 0) q0.push_back(it); else q1.push_back(it);
    endtask

    // Expected words for a fill, built byte by byte from the requirements.
    task automatic push_fill(input int ch, input int s, input int e,
                             input bit f24, input bit f32, input logic [31:0] v);
        int    esz;
        int    cur_w;
        item_t it;
        esz = f24 ? 3 : (f32 ? 4 : 2);
        cur_w = -1;
        it.a = '0; it.d = '0; it.be = '0;
        for (int el = s; el + esz <= e; el += esz) begin
            for (int j = 0; j < esz; j++) begin
                int b;
                logic [7:0] bv;
                b = el + j;
                if (f24) bv = (j == 0) ? v[23:16] : ((j == 1) ? v[15:8] : v[7:0]);
                else     bv = v[8*j +: 8];
                if ((b >> 2) != cur_w) begin
                    if (cur_w >= 0) push_item(ch, it);
                    cur_w = b >> 2;
                    it.a = 16'(cur_w << 2); it.d = '0; it.be = '0;
                end
                it.be[b & 3] = 1'b1;
                it.d[8*(b & 3) +: 8] = bv;
            end
        end
        if (cur_w >= 0) push_item(ch, it);
    endtask

    task automatic start_fill(input int ch, input int s, input int e,
                              input bit f24, input bit f32, input logic [31:0] v);
        push_fill(ch, s, e, f24, f32, v);
        reg_write(ch, 0, 32'(s));
        reg_write(ch, 1, 32'(e));
        reg_write(ch, 2, v);
        reg_write(ch, 3, {28'd0, f24, f32, 1'b0, 1'b1});
    endtask

    task automatic wait_idle(input int ch);
        logic [31:0] r;
        for (int n = 0; n < 2000; n++) begin
            reg_read(ch, 3, r);
            if (!r[0]) break;
            @(posedge clk);
            #1;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Memory ready pattern, changed just after each rising edge.
    always begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = rdy_rand ? lfsr[0] : 1'b1;
    end

    // Monitor: interrupt timing, stall stability, priority and scoreboard compare.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                if (exp_irq[c] || irq[c]) chk(irq[c] == exp_irq[c], "R6", "irq pulse", irq[c], exp_irq[c]);
            end
            exp_irq = 2'b00;
            if (hold_prev)
                chk(mem_valid && mem_addr == prev_a && mem_wdata == prev_d && mem_be == prev_be,
                    "R9", "stalled word held", {mem_addr, mem_be}, {prev_a, prev_be});
            if (mem_valid && mem_ready) begin
                int    c;
                item_t it;
                c = mem_addr[15] ? 1 : 0;
                if (c == 1 && ch0_armed && q0.size() > 0)
                    chk(1'b0, "R9", "channel 1 won over channel 0", mem_addr, q0[0].a);
                if ((c == 0 && q0.size() == 0) || (c == 1 && q1.size() == 0)) begin
                    chk(1'b0, "R4", "unexpected write", mem_addr, 0);
                end else begin
                    it = (c == 0) ? q0.pop_front() : q1.pop_front();
                    chk(mem_addr == it.a, "R4", "word address", mem_addr, it.a);
                    chk(mem_be == it.be, "R3", "byte enables", mem_be, it.be);
                    chk(mem_wdata == it.d, "R3", "data", mem_wdata, it.d);
                    if ((c == 0 && q0.size() == 0) || (c == 1 && q1.size() == 0)) begin
                        exp_irq[c] = 1'b1;
                        if (c == 0) ch0_armed = 1'b0;
                    end
                end
            end
            hold_prev = mem_valid && !mem_ready;
            prev_a = mem_addr; prev_d = mem_wdata; prev_be = mem_be;
        end
    end

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R10: reset state
        for (int ch = 0; ch < 2; ch++)
            for (int s = 0; s < 4; s++) begin
                reg_read(ch, s, r);
                chk(r == 0, "R10", "register after reset", r, 0);
            end
        chk(!mem_valid && irq == 2'b00, "R10", "port idle after reset", {mem_valid, irq}, 0);

        // R1: register read-back
        reg_write(1, 0, 32'h0000_8123);
        reg_write(1, 1, 32'h0000_8456);
        reg_write(1, 2, 32'hDEAD_BEEF);
        reg_read(1, 0, r); chk(r == 32'h8123, "R1", "start read-back", r, 32'h8123);
        reg_read(1, 1, r); chk(r == 32'h8456, "R1", "end read-back", r, 32'h8456);
        reg_read(1, 2, r); chk(r == 32'hDEADBEEF, "R1", "value read-back", r, 32'hDEADBEEF);
        reg_read(0, 2, r); chk(r == 0, "R1", "other channel untouched", r, 0);

        // R3: aligned 32-bit fill
        start_fill(0, 16'h0100, 16'h0110, 1'b0, 1'b1, 32'h1122_3344);
        wait_idle(0);
        reg_read(0, 3, r); chk(r[1:0] == 2'b10, "R6", "finished after 32-bit fill", r[1:0], 2'b10);

        // R4: unaligned 16-bit fill with odd end
        start_fill(0, 16'h0202, 16'h020B, 1'b0, 1'b0, 32'h0000_A5C3);
        wait_idle(0);

        // R3: packed triples across word boundaries
        start_fill(0, 16'h0301, 16'h030E, 1'b1, 1'b0, 32'h00AA_BBCC);
        wait_idle(0);

        // R2: both flags set, triple wins; random ready stalls (R9)
        rdy_rand = 1'b1;
        start_fill(1, 16'h8402, 16'h8431, 1'b1, 1'b1, 32'h0012_3456);
        wait_idle(1);
        rdy_rand = 1'b0;

        // R5: zero start address
        reg_write(0, 0, 32'h0);
        reg_write(0, 1, 32'h40);
        reg_write(0, 3, 32'h0);
        reg_write(0, 3, 32'h1);
        reg_read(0, 3, r); chk(r[1:0] == 2'b10, "R5", "zero start handshake", r[1:0], 2'b10);
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            chk(!mem_valid, "R5", "no write for zero start", mem_valid, 0);
        end
        @(posedge clk); #1;

        // R6: nonzero start but no whole element fits
        reg_write(0, 0, 32'h0400);
        reg_write(0, 1, 32'h0401);
        reg_write(0, 3, 32'h0);
        reg_write(0, 3, 32'h1);
        exp_irq[0] = 1'b1;
        reg_read(0, 3, r); chk(r[1:0] == 2'b10, "R6", "empty region finishes", r[1:0], 2'b10);
        repeat (3) @(posedge clk); #1;

        // R8: finished clears only on written zero
        reg_write(0, 3, 32'h2);
        reg_read(0, 3, r); chk(r[1] == 1'b1, "R8", "write 1 keeps finished", r[1], 1);
        reg_write(0, 3, 32'h0);
        reg_read(0, 3, r); chk(r[1] == 1'b0, "R8", "write 0 clears finished", r[1], 0);

        // R7: writes to a busy channel are ignored
        rdy_rand = 1'b1;
        start_fill(1, 16'h8100, 16'h8180, 1'b0, 1'b0, 32'h0000_7E81);
        reg_write(1, 0, 32'h9000);
        reg_write(1, 3, 32'h9);
        reg_read(1, 0, r); chk(r == 32'h8100, "R7", "start locked while busy", r, 32'h8100);
        reg_read(1, 3, r); chk(r[3:2] == 2'b00, "R7", "flags locked while busy", r[3:2], 0);
        wait_idle(1);
        rdy_rand = 1'b0;

        // R9: channel 0 preempts channel 1 between words
        start_fill(1, 16'h8800, 16'h8840, 1'b0, 1'b1, 32'hCAFE_F00D);
        repeat (2) @(posedge clk); #1;
        start_fill(0, 16'h0500, 16'h0510, 1'b0, 1'b1, 32'h0BAD_0BAD);
        ch0_armed = 1'b1;
        wait_idle(0);
        wait_idle(1);

        chk(q0.size() == 0 && q1.size() == 0, "R4", "all expected words seen",
            q0.size() + q1.size(), 0);
        finish_up();
    end

endmodule